// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block sits between an 8-bit processor core and a bus that shares its low address byte with the data byte. The core hands it one machine-cycle request at a time. A request carries a cycle type, a 16-bit address, a write byte and a flag that lengthens an opcode fetch. The sequencer then steps through the T-states of that cycle, one clock per T-state. It drives the high address byte, the shared address/data byte and its output enable, an address latch enable pulse, active-low read and write strobes, an I/O-versus-memory select and two status bits.

For every reading cycle, the byte on the shared bus is captured before the read strobe is released. The captured byte is returned with a one-clock done pulse. Requests may be chained with no gap: a request offered in the final T-state of a cycle starts the next cycle on the following clock. A three-byte direct load therefore becomes four back-to-back cycles: an opcode fetch and three memory reads.

Top module: `bus_cycle_seq`

## Requirements
- R1: Cycle type codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. The two memory cycles and the two I/O cycles last 3 T-states. An opcode fetch lasts 4 T-states.
- R2: With `req_long_i` high, an opcode fetch lasts 6 T-states. For every other cycle type the flag has no effect and the cycle still lasts 3 T-states.
- R3: In T1, `ale_o` is high, `ad_oe_o` is high with the low address byte on `ad_o`, and `addr_hi_o` carries the high address byte. `ale_o` is low in every other T-state and when idle.
- R4: `rd_no` is low in T2 and T3 of an opcode fetch, a memory read or an I/O read. `wr_no` is low in T2 and T3 of a memory write or an I/O write. Both strobes are high in T1, T4–T6 and idle, and they are never low together.
- R5: From T1 to the last T-state, `io_m_o` is 0 for memory cycles and 1 for I/O cycles. {`s1_o`,`s0_o`} is 11 for an opcode fetch, 10 for a memory or I/O read and 01 for a memory or I/O write. When idle, both `io_m_o` and the status bits are 0.
- R6: In I/O cycles, `addr_hi_o` carries the 8-bit port number, which is address bits 7:0, the same byte that T1 puts on `ad_o`.
- R7: In reading cycles, `ad_oe_o` is low from T2 to the end of the cycle. In writing cycles, `ad_oe_o` is high and `ad_o` equals the request's write byte in T2 and T3.
- R8: In a reading cycle, `ad_i` is sampled at the clock edge that ends T3. In the T-state that follows (T4 for a fetch), `rdata_o` holds the sampled byte and `done_o` is high for exactly one clock. Writing cycles raise no done pulse.
- R9: `req_ready_o` is high when idle and in the last T-state of a cycle, and low otherwise. A request offered while it is low is ignored. A request accepted in the last T-state starts T1 on the next clock.
- R10: An active-low asynchronous reset returns the block to idle. After reset `ale_o` is low, both strobes are high, `ad_oe_o` and `done_o` are low, `rdata_o` is 0 and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | T-state clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cycle request present |
| req_type_i | input | 3 | Cycle type code |
| req_addr_i | input | 16 | Memory address or I/O port (bits 7:0) |
| req_wdata_i | input | 8 | Byte to write |
| req_long_i | input | 1 | Stretch an opcode fetch to 6 T-states |
| req_ready_o | output | 1 | Request can be accepted this clock |
| ad_i | input | 8 | Shared bus input for read data |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Shared bus output: low address or write data |
| ad_oe_o | output | 1 | Shared bus output enable |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for I/O, 0 for memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock pulse after a read capture |

## Verification
The bench chains the four cycles of a direct load back to back. A sequencer that inserted an idle clock, or that ignored a request arriving in the last T-state, would misalign the ALE pulses and break the chain. It also sends a long flag with a memory read, where a design that stretched every cycle would keep the read strobe or the ready signal wrong for extra states. The I/O cycles use a high address byte that differs from the port number, so copying the wrong byte onto `addr_hi_o` is exposed. A request held during T1 and T2, together with a reset in the middle of a write, shows whether the design starts a cycle early or leaves a strobe low after reset.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH  = 3'd0,
    CYC_MEM_RD = 3'd1,
    CYC_MEM_WR = 3'd2,
    CYC_IO_RD  = 3'd3,
    CYC_IO_WR  = 3'd4
  } cyc_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_1    = 3'd1,
    TS_2    = 3'd2,
    TS_3    = 3'd3,
    TS_4    = 3'd4,
    TS_5    = 3'd5,
    TS_6    = 3'd6
  } tstate_e;

  typedef struct packed {
    logic fetch;
    logic wr;
    logic io;
    logic lng;
  } cyc_attr_t;

  function automatic cyc_attr_t cyc_decode(input logic [2:0] typ, input logic lng);
    cyc_attr_t a;
    a.fetch = (typ == CYC_FETCH);
    a.wr    = (typ == CYC_MEM_WR) || (typ == CYC_IO_WR);
    a.io    = (typ == CYC_IO_RD)  || (typ == CYC_IO_WR);
    a.lng   = lng && a.fetch;  // stretch applies to fetch only
    return a;
  endfunction

endpackage

// File: rtl/bus_seq_ctl.sv
module bus_seq_ctl
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_long_i,
  output logic              ready_o,
  output tstate_e           tstate_o,
  output logic              fetch_o,
  output logic              wr_o,
  output logic              io_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  tstate_e           tst_q, last_ts;
  cyc_attr_t         attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  always_comb begin
    if (attr_q.fetch) last_ts = attr_q.lng ? TS_6 : TS_4;
    else              last_ts = TS_3;
  end

  assign ready_o = (tst_q == TS_IDLE) || (tst_q == last_ts);
  assign accept  = req_valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tst_q   <= TS_IDLE;
      attr_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      tst_q   <= TS_1;
      attr_q  <= cyc_decode(req_type_i, req_long_i);
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end else if (tst_q == TS_IDLE || tst_q == last_ts) begin
      tst_q   <= TS_IDLE;
    end else begin
      tst_q   <= tstate_e'(tst_q + 3'd1);
    end
  end

  assign tstate_o = tst_q;
  assign fetch_o  = attr_q.fetch;
  assign wr_o     = attr_q.wr;
  assign io_o     = attr_q.io;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;

endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  tstate_e                  tstate_i,
  input  logic                     fetch_i,
  input  logic                     wr_i,
  input  logic                     io_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic                     io_m_o,
  output logic                     s1_o,
  output logic                     s0_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  always_comb begin
    addr_hi_o = '0;
    ad_o      = '0;
    ad_oe_o   = 1'b0;
    ale_o     = 1'b0;
    rd_no     = 1'b1;
    wr_no     = 1'b1;
    io_m_o    = 1'b0;
    s1_o      = 1'b0;
    s0_o      = 1'b0;
    if (tstate_i != TS_IDLE) begin
      io_m_o    = io_i;
      s1_o      = !wr_i;
      s0_o      = wr_i || fetch_i;
      // I/O port number is mirrored onto the high byte
      addr_hi_o = io_i ? HI_W'(addr_i[DATA_W-1:0]) : addr_i[ADDR_W-1:DATA_W];
    end
    case (tstate_i)
      TS_1: begin
        ale_o   = 1'b1;
        ad_oe_o = 1'b1;
        ad_o    = addr_i[DATA_W-1:0];
      end
      TS_2, TS_3: begin
        if (wr_i) begin
          wr_no   = 1'b0;
          ad_oe_o = 1'b1;
          ad_o    = wdata_i;
        end else begin
          rd_no   = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bus_seq_cap.sv
module bus_seq_cap
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           tstate_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  logic capture;

  // sample at the edge that ends T3, while the read strobe is still low
  assign capture = (tstate_i == TS_3) && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= capture;
      if (capture) rdata_o <= ad_i;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [2:0]               req_type_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     req_long_i,
  output logic                     req_ready_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic                     io_m_o,
  output logic                     s1_o,
  output logic                     s0_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);

  tstate_e           tstate;
  logic              cyc_fetch, cyc_wr, cyc_io;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_wdata;

  bus_seq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_type_i  (req_type_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_long_i  (req_long_i),
    .ready_o     (req_ready_o),
    .tstate_o    (tstate),
    .fetch_o     (cyc_fetch),
    .wr_o        (cyc_wr),
    .io_o        (cyc_io),
    .addr_o      (cyc_addr),
    .wdata_o     (cyc_wdata)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .tstate_i  (tstate),
    .fetch_i   (cyc_fetch),
    .wr_i      (cyc_wr),
    .io_i      (cyc_io),
    .addr_i    (cyc_addr),
    .wdata_i   (cyc_wdata),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .io_m_o    (io_m_o),
    .s1_o      (s1_o),
    .s0_o      (s0_o)
  );

  bus_seq_cap #(.DATA_W(DATA_W)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tstate_i (tstate),
    .wr_i     (cyc_wr),
    .ad_i     (ad_i),
    .rdata_o  (rdata_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_ready_o,
  input logic                     ad_oe_o,
  input logic                     ale_o,
  input logic                     rd_no,
  input logic                     wr_no,
  input logic                     done_o
);

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  // R4
  strobe_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $fell(wr_no)) |-> $past(ale_o));

  // R3
  ale_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  // R7
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  ale_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> $past(req_valid_i && req_ready_o));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .ad_oe_o     (ad_oe_o),
  .ale_o       (ale_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .done_o      (done_o)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

  typedef struct packed {
    logic [2:0]  typ;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        lng;
    logic [7:0]  rd;
    logic        chain;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'h0210, 8'h00, 1'b0, 8'h3A, 1'b1},  // direct load: fetch
    '{3'd1, 16'h0211, 8'h00, 1'b0, 8'h10, 1'b1},  // operand low
    '{3'd1, 16'h0212, 8'h00, 1'b0, 8'h20, 1'b1},  // operand high
    '{3'd1, 16'h2010, 8'h00, 1'b0, 8'h5A, 1'b0},  // data read
    '{3'd2, 16'h3FFE, 8'h44, 1'b0, 8'hEE, 1'b0},  // memory write
    '{3'd3, 16'h1281, 8'h00, 1'b0, 8'hC3, 1'b0},  // I/O read, hi byte differs
    '{3'd4, 16'h7F40, 8'hA5, 1'b0, 8'h11, 1'b1},  // I/O write
    '{3'd0, 16'h0400, 8'h00, 1'b1, 8'h21, 1'b1},  // long fetch
    '{3'd1, 16'h0401, 8'h00, 1'b1, 8'h0D, 1'b0},  // long flag on a read
    '{3'd0, 16'hABCD, 8'h00, 1'b0, 8'h7E, 1'b1},  // short fetch
    '{3'd2, 16'h2009, 8'h06, 1'b0, 8'h99, 1'b0}   // write after fetch
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_type_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_long_i = 1'b0;
  logic        req_ready_o;
  logic [7:0]  ad_i = '0;
  logic [7:0]  addr_hi_o, ad_o, rdata_o;
  logic        ad_oe_o, ale_o, rd_no, wr_no, io_m_o, s1_o, s0_o, done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  bus_cycle_seq i_bus_cycle_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_type_i(req_type_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_long_i(req_long_i),
    .req_ready_o(req_ready_o), .ad_i(ad_i), .addr_hi_o(addr_hi_o), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no), .io_m_o(io_m_o),
    .s1_o(s1_o), .s0_o(s0_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic drive_req(input vec_t v);
    req_valid_i = 1'b1;
    req_type_i  = v.typ;
    req_addr_i  = v.addr;
    req_wdata_i = v.wd;
    req_long_i  = v.lng;
  endtask

  function automatic int cyc_len(input vec_t v);
    if (v.typ == 3'd0) return v.lng ? 6 : 4;
    return 3;
  endfunction

  task automatic check_state(input vec_t v, input int s, input int len);
    logic is_w, is_io, is_f, strobe;
    is_w   = (v.typ == 3'd2) || (v.typ == 3'd4);
    is_io  = (v.typ == 3'd3) || (v.typ == 3'd4);
    is_f   = (v.typ == 3'd0);
    strobe = (s == 2) || (s == 3);
    chk("R3 ale", ale_o, s == 1);
    chk("R4 rd_n", rd_no, !(strobe && !is_w));
    chk("R4 wr_n", wr_no, !(strobe && is_w));
    chk("R5 io_m", io_m_o, is_io);
    chk("R5 status", {s1_o, s0_o}, is_f ? 2'b11 : (is_w ? 2'b01 : 2'b10));
    chk("R6 addr_hi", addr_hi_o, is_io ? v.addr[7:0] : v.addr[15:8]);
    chk("R7 ad_oe", ad_oe_o, (s == 1) || (is_w && strobe));
    if (s == 1) chk("R3 ad low addr", ad_o, v.addr[7:0]);
    else if (is_w && strobe) chk("R7 ad wdata", ad_o, v.wd);
    chk("R1 R2 R9 ready", req_ready_o, s == len);
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " ale"}, ale_o, 1'b0);
    chk({tag, " rd_n"}, rd_no, 1'b1);
    chk({tag, " wr_n"}, wr_no, 1'b1);
    chk({tag, " ad_oe"}, ad_oe_o, 1'b0);
    chk({tag, " ready"}, req_ready_o, 1'b1);
    chk({tag, " io_m/status"}, {io_m_o, s1_o, s0_o}, 3'b000);
  endtask

  initial begin
    bit chained, pend_done;
    logic [7:0] pend_rd;
    chained = 1'b0;
    pend_done = 1'b0;
    pend_rd = '0;

    // R10 reset state
    repeat (3) @(negedge clk_i);
    check_idle("R10 reset");
    chk("R10 done", done_o, 1'b0);
    chk("R10 rdata", rdata_o, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int len;
      logic is_rd;
      v = TBL[i];
      len = cyc_len(v);
      is_rd = !((v.typ == 3'd2) || (v.typ == 3'd4));
      if (!chained) begin
        @(negedge clk_i);
        drive_req(v);
      end
      for (int s = 1; s <= len; s++) begin
        logic exp_done;
        @(negedge clk_i);
        if (s == 1) req_valid_i = 1'b0;
        ad_i = v.rd;
        check_state(v, s, len);
        exp_done = (s == 1 && pend_done) || (v.typ == 3'd0 && s == 4);
        chk("R8 done", done_o, exp_done);
        if (exp_done) chk("R8 rdata", rdata_o, (s == 1) ? pend_rd : v.rd);
        if (s == len && v.chain) drive_req(TBL[i+1]);
      end
      pend_done = is_rd && (len == 3) && v.chain;
      pend_rd   = v.rd;
      chained   = v.chain;
      if (!v.chain) begin
        @(negedge clk_i);
        check_idle("R1 end of cycle");
        chk("R8 done after cycle", done_o, is_rd && (len == 3));
        if (is_rd && (len == 3)) chk("R8 rdata after cycle", rdata_o, v.rd);
      end
    end

    // R9: request held during T1/T2 is ignored
    @(negedge clk_i);
    drive_req('{3'd1, 16'h1111, 8'h00, 1'b0, 8'h99, 1'b0});
    @(negedge clk_i);  // T1
    ad_i = 8'h99;
    drive_req('{3'd2, 16'h2222, 8'h55, 1'b0, 8'h00, 1'b0});
    chk("R9 ready in T1", req_ready_o, 1'b0);
    @(negedge clk_i);  // T2
    chk("R9 ready in T2", req_ready_o, 1'b0);
    chk("R9 no restart ale", ale_o, 1'b0);
    chk("R9 addr kept", addr_hi_o, 8'h11);
    chk("R9 still reading", {rd_no, wr_no}, 2'b01);
    req_valid_i = 1'b0;
    @(negedge clk_i);  // T3
    chk("R9 addr kept T3", addr_hi_o, 8'h11);
    chk("R9 ready in T3", req_ready_o, 1'b1);
    @(negedge clk_i);
    check_idle("R9 ignored request");
    chk("R8 done after held", done_o, 1'b1);
    chk("R8 rdata after held", rdata_o, 8'h99);

    // R10: reset in the middle of a write
    @(negedge clk_i);
    drive_req('{3'd2, 16'h5678, 8'h3C, 1'b0, 8'h00, 1'b0});
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);  // T2
    chk("R10 write strobe before reset", wr_no, 1'b0);
    rst_ni = 1'b0;
    #1;
    check_idle("R10 mid-cycle reset");
    chk("R10 rdata cleared", rdata_o, 8'h00);
    chk("R10 done cleared", done_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R10 after release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule